// File: doc/BRIEF.md
# Byte-Mapped Interrupt Aggregator

This block gathers up to 24 peripheral interrupt requests and folds them into a single active-high cascade line for a host processor. Requests are grouped into three banks of eight. Each bank has a status byte and a mask byte, reached over a simple byte-wide register bus with an address, a read strobe, a write strobe, write data and registered read data.

Every raw request passes through a two-flop synchroniser. All sources but one are edge-type. A rising edge on an edge-type source is latched in its status bit only while that source's mask bit is 1. Reading a bank's status byte clears the latched edge bits of that bank. No separate acknowledge register exists. One source, chosen by a parameter, is level-type. Its status bit simply follows the synchronised input.

The cascade output is high while any source has both its status bit and its mask bit set. The host detects the cascade on a rising edge. It then reads the status bytes to find and retire the events. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `irq_byte_aggregator`

## Requirements
- R1: After reset all mask bytes read 0x00, the cascade output is 0, and every status byte reads 0x00 while all inputs are low.
- R2: Register address 2*b+1 holds the mask byte of bank b (b = 0, 1, 2). A write there takes effect and reads back unchanged. A bit value of 1 enables its source. A write to a status address (2*b) changes nothing.
- R3: A rising edge on an enabled edge-type source sets its status bit. Address 2*b reads the status byte of bank b, and source n appears at bit n mod 8 of bank n div 8. A read returns the status before that read takes effect. It then clears every latched edge bit of that bank.
- R4: A rising edge on an edge-type source whose mask bit is 0 is not recorded. Setting the mask bit later neither sets the status bit nor raises the cascade.
- R5: The level-type source (parameter LEVEL_SRC, default source 0) has a status bit equal to the synchronised input. A status read does not clear that bit.
- R6: The cascade output is 1 exactly while some source has both its status and mask bits at 1. Clearing the mask of a latched source drops the cascade, and the latched status bit stays readable.
- R7: When a new edge is detected in the same cycle as the clearing read of its bank, the bit stays set. That read returns the bit as 0, and the next read returns it as 1.
- R8: Only 0-to-1 transitions are recorded. A falling input does not set a status bit.
- R9: A status read clears only the bank it addresses. Latched bits of other banks are kept.
- R10: Reads of addresses 6 and 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| irq_in | input | 24 | Raw interrupt requests, source n on bit n |
| bus_addr | input | 3 | Register byte address |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the strobe |
| cascade_irq | output | 1 | Combined interrupt to host, active high |

## Verification
The in-module assertions check on every cycle that masked edges never enter the latch, that a clearing read empties the latch except for edges arriving in the same cycle, that masks change only on a write to their address, and that each rise or fall of the cascade is backed by the pending set in the previous cycle. Other behaviours show only in the bench's scenarios. These are the address map and bit positions, the pre-clear value returned by a read, the lost-while-masked edge after unmasking, the level source surviving reads, the per-bank scope of clearing, and the exact read ordering around an edge that collides with a read.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Bits per register bank
  localparam int unsigned BANK_W = 8;

  // Low address bit picks the register kind within a bank
  typedef enum logic {
    REG_STATUS = 1'b0,
    REG_MASK   = 1'b1
  } reg_kind_e;

  // Build the set of edge-type bits for one bank
  function automatic logic [BANK_W-1:0] edge_select(input bit has_level,
                                                    input int unsigned level_bit);
    logic [BANK_W-1:0] sel;
    sel = '1;
    if (has_level) sel[level_bit] = 1'b0;
    return sel;
  endfunction

endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/irqc_sync_edge.sv
module irqc_sync_edge #(
  parameter int unsigned WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dsync,
  output logic [WIDTH-1:0] rise
);

  logic [WIDTH-1:0] meta_q, sync_q, prev_q;
  logic [WIDTH-1:0] meta_d, sync_d, prev_d;

  always_comb begin
    meta_d = din;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign dsync = sync_q;
  assign rise  = sync_q & ~prev_q;

endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
#(
  parameter bit          HAS_LEVEL = 1'b0,
  parameter int unsigned LEVEL_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] sync_in,
  input  logic [BANK_W-1:0] rise,
  input  logic              wr_mask,
  input  logic [BANK_W-1:0] wdata,
  input  logic              rd_clr,
  output logic [BANK_W-1:0] mask_q,
  output logic [BANK_W-1:0] status,
  output logic              pending_any
);

  localparam logic [BANK_W-1:0] EDGE_SEL = edge_select(HAS_LEVEL, LEVEL_BIT);

  logic [BANK_W-1:0] mask_d;
  logic [BANK_W-1:0] latch_q, latch_d;
  logic [BANK_W-1:0] capture;
  logic [BANK_W-1:0] level_vec;

  // Edges are only captured while enabled; a new edge overrides a clear
  always_comb begin
    capture = rise & mask_q & EDGE_SEL;
    latch_d = (rd_clr ? '0 : latch_q) | capture;
    mask_d  = wr_mask ? wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      mask_q  <= '0;
    end else begin
      latch_q <= latch_d;
      mask_q  <= mask_d;
    end
  end

  // Level source bypasses the latch
  assign level_vec   = sync_in & ~EDGE_SEL;
  assign status      = (latch_q & EDGE_SEL) | level_vec;
  assign pending_any = |(status & mask_q);

  a_r4_no_capture_masked: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_q & ~$past(mask_q) & ~$past(latch_q)) == '0));

  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> ((latch_q & ~$past(rise & mask_q)) == '0));

  a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|capture) |=> ((latch_q & $past(capture)) == $past(capture)));

  a_r2_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q));

endmodule

// File: rtl/irq_byte_aggregator.sv
module irq_byte_aggregator
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned LEVEL_SRC = 0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0]   irq_in,
  input  logic [$clog2(2*NUM_BANKS)-1:0] bus_addr,
  input  logic                          bus_rd,
  input  logic                          bus_wr,
  input  logic [BANK_W-1:0]             bus_wdata,
  output logic [BANK_W-1:0]             bus_rdata,
  output logic                          cascade_irq
);

  localparam int unsigned NSRC   = NUM_BANKS * BANK_W;
  localparam int unsigned AW     = $clog2(2 * NUM_BANKS);
  localparam int unsigned BIDX_W = AW - 1;
  localparam int unsigned LVL_BANK = LEVEL_SRC / BANK_W;
  localparam int unsigned LVL_BIT  = LEVEL_SRC % BANK_W;

  logic rst_n_i;

  irqc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  logic [NSRC-1:0] irq_sync, irq_rise;

  irqc_sync_edge #(.WIDTH(NSRC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .din   (irq_in),
    .dsync (irq_sync),
    .rise  (irq_rise)
  );

  // Address decode
  logic [BIDX_W-1:0] bank_idx;
  reg_kind_e         kind;

  assign bank_idx = bus_addr[AW-1:1];
  assign kind     = reg_kind_e'(bus_addr[0]);

  logic [BANK_W-1:0] stat_arr [NUM_BANKS];
  logic [BANK_W-1:0] mask_arr [NUM_BANKS];
  logic [NUM_BANKS-1:0] pend_vec;
  logic [NUM_BANKS-1:0] clr_vec, wr_vec;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign clr_vec[b] = bus_rd && (bank_idx == BIDX_W'(b)) && (kind == REG_STATUS);
    assign wr_vec[b]  = bus_wr && (bank_idx == BIDX_W'(b)) && (kind == REG_MASK);

    irqc_bank #(
      .HAS_LEVEL (LVL_BANK == b),
      .LEVEL_BIT (LVL_BIT)
    ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n_i),
      .sync_in     (irq_sync[b*BANK_W +: BANK_W]),
      .rise        (irq_rise[b*BANK_W +: BANK_W]),
      .wr_mask     (wr_vec[b]),
      .wdata       (bus_wdata),
      .rd_clr      (clr_vec[b]),
      .mask_q      (mask_arr[b]),
      .status      (stat_arr[b]),
      .pending_any (pend_vec[b])
    );
  end

  // Read path and cascade output, registered
  logic [BANK_W-1:0] rdata_d, rdata_q;
  logic              casc_d, casc_q;
  logic [BANK_W-1:0] sel_byte;

  always_comb begin
    sel_byte = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_idx == BIDX_W'(b)) begin
        sel_byte = (kind == REG_MASK) ? mask_arr[b] : stat_arr[b];
      end
    end
    rdata_d = bus_rd ? sel_byte : rdata_q;
    casc_d  = |pend_vec;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rdata_q <= '0;
      casc_q  <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      casc_q  <= casc_d;
    end
  end

  assign bus_rdata   = rdata_q;
  assign cascade_irq = casc_q;

  a_r6_cascade_rise: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(cascade_irq) |-> $past(|pend_vec));

  a_r6_cascade_fall: assert property (@(posedge clk) disable iff (!rst_n_i)
    $fell(cascade_irq) |-> !$past(|pend_vec));

  a_r9_single_bank_clear: assert property (@(posedge clk) disable iff (!rst_n_i)
    $onehot0(clr_vec));

endmodule

// File: tb/irq_byte_aggregator_test.sv
module irq_byte_aggregator_test;

  logic        clk;
  logic        rst_n;
  logic [23:0] irq_in;
  logic [2:0]  bus_addr;
  logic        bus_rd;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        cascade_irq;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen;

  irq_byte_aggregator uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_in      (irq_in),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .cascade_irq (cascade_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Monitor: a read strobe sampled at one edge yields data after it
  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen === 1'b1) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_casc(input logic e, input string t);
    checks++;
    if (cascade_irq !== e) begin
      errors++;
      $display("FAIL %s: cascade=%b expected=%b", t, cascade_irq, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_in = '0; bus_addr = '0; bus_rd = 1'b0;
    bus_wr = 1'b0; bus_wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    chk_casc(1'b0, "R1 cascade after reset");
    rd(3'd1, 8'h00, "R1 mask0 reset");
    rd(3'd3, 8'h00, "R1 mask1 reset");
    rd(3'd5, 8'h00, "R1 mask2 reset");
    rd(3'd0, 8'h00, "R1 status0 reset");

    // R2 mask write/readback, status write ignored
    wr(3'd1, 8'hA5);
    rd(3'd1, 8'hA5, "R2 mask0 readback");
    wr(3'd0, 8'hFF);
    rd(3'd0, 8'h00, "R2 status write ignored");
    rd(3'd1, 8'hA5, "R2 mask0 unchanged by status write");

    // R10 unused addresses
    rd(3'd6, 8'h00, "R10 address 6");
    rd(3'd7, 8'h00, "R10 address 7");

    // R3 edge latch, read reports then clears
    wr(3'd1, 8'hFF);
    irq_in[3] = 1'b1;
    tick(6);
    chk_casc(1'b1, "R6 cascade on latched edge");
    rd(3'd0, 8'h08, "R3 status0 reports edge");
    rd(3'd0, 8'h00, "R3 status0 cleared by read");
    tick(2);
    chk_casc(1'b0, "R6 cascade low after clear");

    // R8 falling edge ignored
    irq_in[3] = 1'b0;
    tick(6);
    rd(3'd0, 8'h00, "R8 falling edge not latched");
    chk_casc(1'b0, "R8 cascade stays low");

    // R4 edge while masked is lost
    wr(3'd3, 8'h00);
    irq_in[9] = 1'b1;
    tick(6);
    chk_casc(1'b0, "R4 cascade low while masked");
    wr(3'd3, 8'h02);
    tick(4);
    chk_casc(1'b0, "R4 cascade low after unmask");
    rd(3'd2, 8'h00, "R4 status1 not recorded");
    irq_in[9] = 1'b0;

    // R5 level source
    irq_in[0] = 1'b1;
    tick(6);
    rd(3'd0, 8'h01, "R5 level status follows input");
    rd(3'd0, 8'h01, "R5 level status survives read");
    chk_casc(1'b1, "R5 cascade from level source");
    irq_in[0] = 1'b0;
    tick(6);
    chk_casc(1'b0, "R5 cascade drops with level input");
    rd(3'd0, 8'h00, "R5 level status low");

    // R9 clear only addressed bank
    wr(3'd3, 8'hFF);
    wr(3'd5, 8'hFF);
    irq_in[12] = 1'b1;
    irq_in[17] = 1'b1;
    tick(6);
    chk_casc(1'b1, "R9 cascade with two banks latched");
    rd(3'd4, 8'h02, "R9 status2 source 17");
    rd(3'd2, 8'h10, "R9 status1 kept after bank2 read");
    tick(2);
    chk_casc(1'b0, "R9 cascade low after both reads");

    // R6 masking a latched source drops cascade, bit stays
    irq_in[17] = 1'b0;
    tick(4);
    irq_in[17] = 1'b1;
    tick(6);
    chk_casc(1'b1, "R6 cascade high on bank2 edge");
    wr(3'd5, 8'h00);
    tick(3);
    chk_casc(1'b0, "R6 cascade low after masking");
    rd(3'd4, 8'h02, "R6 latched bit still readable");
    tick(2);
    chk_casc(1'b0, "R6 cascade stays low");

    // R7 edge colliding with clearing read
    wr(3'd1, 8'hFF);
    irq_in[5] = 1'b1;          // before edge E0
    @(negedge clk);            // after E0: first stage
    @(negedge clk);            // after E1: rise detected
    bus_addr = 3'd0; bus_rd = 1'b1;
    exp_q.push_back(8'h00);
    tag_q.push_back("R7 colliding read returns pre-value");
    @(negedge clk);            // after E2: read and edge together
    bus_rd = 1'b0;
    @(negedge clk);
    rd(3'd0, 8'h20, "R7 edge kept after colliding read");
    rd(3'd0, 8'h00, "R7 cleared by following read");

    tick(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule